// File: doc/BRIEF.md
# Deep-Sleep Wake-Up Controller

This controller runs from an always-on clock beside a processor core. When the core enters deep sleep, the controller keeps its own copy of the core's interrupt enables, so it can tell when a wake-up is needed while every core clock is stopped. If power-down is built in and no debugger is attached, it asks a power manager to remove core power. Before doing so it issues a retention save pulse.

An enabled interrupt on any line brings the core back. The controller first asks the power manager to restore supply and then pulses a retention restore. It then turns the core clocks back on, and it releases the core once the power manager stops holding the wake. The lines that caused the wake are reported to the core when it is released. Power-down can be removed with a parameter, which leaves only clock-stop sleep.

Top module: `wake_ctrl`

## Requirements
- R1: The enable copy is written from `mask_i` only when `mask_ld_i` is high in the running or mask-capture phase. A load in any other phase is ignored. Reset clears every enable bit to 0, so no line can wake the core.
- R2: A line whose enable bit is 0 never starts a wake-up and never appears in `wake_reason_o`.
- R3: Outside the running phase, an enabled line that is high for even one cycle is latched as pending. Bit k of `wake_reason_o` is pending line k. It shows the latched lines from the first cycle of release, reads 0 at all other times, and is cleared at the next sleep entry.
- R4: After reset, the core is released with clocks enabled. With `deep_sleep_i` high in the running phase, the next cycle is one mask-capture cycle (clocks on, core held). The cycle after that is clock-stopped (`core_clk_en_o` low), unless a wake is pending.
- R5: From clock-stop, with power-down built in and no debugger, the next cycle raises `pd_req_o`, with `ret_save_o` high in that first cycle only. `pd_req_o` stays high until `pd_ack_i` is high, then falls. The block stays powered down until `pd_ack_i` is low and a wake is pending.
- R6: A wake while powered down raises `pu_req_o` until `pu_ack_i` is high. The next cycle drops `pu_req_o` and pulses `ret_restore_o` for one cycle. Clocks return once `pu_ack_i` is low.
- R7: In the wake-hold phase, clocks are on and the core stays held while `pmu_hold_i` is high. The cycle after `pmu_hold_i` is seen low, the core is released.
- R8: While `dbg_conn_i` is high, `pd_req_o` never rises. The block stays in clock-stop and still wakes on an enabled line.
- R9: An enabled line during mask capture, or during a power-down request that has not been acknowledged, abandons the entry. The block goes straight to wake-hold and keeps the line pending.
- R10: With `PWRDN_EN` = 0, no power request or retention output is ever asserted. The core stays clock-stopped until an enabled line wakes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| mask_ld_i | input | 1 | Load strobe for the enable copy |
| mask_i | input | NUM_IRQ | Core interrupt enables to copy |
| deep_sleep_i | input | 1 | Core requests deep sleep |
| dbg_conn_i | input | 1 | Debugger attached |
| pd_req_o | output | 1 | Power-down request to power manager |
| pd_ack_i | input | 1 | Power-down acknowledge |
| pu_req_o | output | 1 | Power-up request to power manager |
| pu_ack_i | input | 1 | Power-up acknowledge |
| ret_save_o | output | 1 | One-cycle retention save pulse |
| ret_restore_o | output | 1 | One-cycle retention restore pulse |
| pmu_hold_i | input | 1 | Power manager delays final release |
| core_clk_en_o | output | 1 | Core clock enable |
| core_release_o | output | 1 | Core released to run |
| wake_reason_o | output | NUM_IRQ | Latched wake lines, valid while released |

## Verification
The hardest cases are the abandoned entries. An enabled line has to arrive exactly in the single mask-capture cycle, or in a power-down request cycle before the acknowledge. The vector table places one-cycle pulses on those exact cycles, then checks that the core returns through wake-hold with the pulse reported. A second instance built without power-down shares the stimulus and shows the clock-stop-only path.

// File: rtl/wake_ctrl_pkg.sv
package wake_ctrl_pkg;
   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_MCAP    = 3'd1,
      ST_CSTOP   = 3'd2,
      ST_PDREQ   = 3'd3,
      ST_PDOWN   = 3'd4,
      ST_PUREQ   = 3'd5,
      ST_RESTORE = 3'd6,
      ST_WHOLD   = 3'd7
   } wake_st_e;
endpackage

// File: rtl/wake_irq_latch.sv
module wake_irq_latch #(
   parameter int NUM_IRQ = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               ld_i,
   input  logic [NUM_IRQ-1:0] ld_data_i,
   input  logic               ld_ok_i,
   input  logic               collect_i,
   input  logic               clear_i,
   input  logic               show_i,
   output logic               hit_o,
   output logic [NUM_IRQ-1:0] reason_o
);
   logic [NUM_IRQ-1:0] mask_q;
   logic [NUM_IRQ-1:0] pend_q;
   logic [NUM_IRQ-1:0] live;

   assign live = irq_i & mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (ld_i && ld_ok_i) begin
         mask_q <= ld_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (clear_i) begin
         pend_q <= '0;
      end else if (collect_i) begin
         pend_q <= pend_q | live;
      end
   end

   assign hit_o    = |(pend_q | live);
   assign reason_o = show_i ? pend_q : '0;

   // R1
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_i && ld_ok_i) |=> $stable(mask_q));

   // R3
   reason_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reason_o != '0) |-> show_i);
endmodule

// File: rtl/wake_seq.sv
module wake_seq
   import wake_ctrl_pkg::*;
#(
   parameter bit PWRDN_EN = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sleep_i,
   input  logic     dbg_i,
   input  logic     hit_i,
   input  logic     dn_ack_i,
   input  logic     up_ack_i,
   input  logic     hold_i,
   output wake_st_e state_o,
   output logic     clk_en_o,
   output logic     release_o,
   output logic     dn_req_o,
   output logic     up_req_o,
   output logic     save_o,
   output logic     restore_o
);
   wake_st_e st_q, st_d;
   logic     pd_ok;
   logic     save_q, restore_q;

   assign pd_ok = PWRDN_EN & ~dbg_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:     if (sleep_i) st_d = ST_MCAP;
         ST_MCAP:    st_d = hit_i ? ST_WHOLD : ST_CSTOP;
         ST_CSTOP: begin
            if (hit_i)      st_d = ST_WHOLD;
            else if (pd_ok) st_d = ST_PDREQ;
         end
         ST_PDREQ: begin
            if (dn_ack_i)   st_d = ST_PDOWN;
            else if (hit_i) st_d = ST_WHOLD;
         end
         ST_PDOWN:   if (hit_i && !dn_ack_i) st_d = ST_PUREQ;
         ST_PUREQ:   if (up_ack_i)  st_d = ST_RESTORE;
         ST_RESTORE: if (!up_ack_i) st_d = ST_WHOLD;
         ST_WHOLD:   if (!hold_i)   st_d = ST_RUN;
         default:    st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_RUN;
         save_q    <= 1'b0;
         restore_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         save_q    <= (st_q == ST_CSTOP) && (st_d == ST_PDREQ);
         restore_q <= (st_q == ST_PUREQ) && (st_d == ST_RESTORE);
      end
   end

   assign state_o   = st_q;
   assign clk_en_o  = (st_q == ST_RUN) || (st_q == ST_MCAP) || (st_q == ST_WHOLD);
   assign release_o = (st_q == ST_RUN);
   assign dn_req_o  = (st_q == ST_PDREQ);
   assign up_req_o  = (st_q == ST_PUREQ);
   assign save_o    = save_q;
   assign restore_o = restore_q;

   generate
      if (!PWRDN_EN) begin : g_clkstop_only
         // R10
         always_comb begin
            if (rst_n) begin
               nopd_quiet_chk: assert (!(dn_req_o || up_req_o || save_o || restore_o));
            end
         end
      end
   endgenerate

   // R4
   always_comb begin
      if (rst_n) begin
         release_clk_chk: assert (!release_o || clk_en_o);
      end
   end

   // R5
   dn_req_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req_o && !dn_ack_i && !hit_i) |=> dn_req_o);

   // R6
   restore_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restore_o) |-> ($past(up_req_o) && !up_req_o));

   // R7
   release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(release_o) |-> $past(!hold_i));

   // R8
   dbg_no_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_i && !dn_req_o) |=> !dn_req_o);
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
   import wake_ctrl_pkg::*;
#(
   parameter int NUM_IRQ  = 8,
   parameter bit PWRDN_EN = 1'b1
) (
   input  logic               clk_aon,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               mask_ld_i,
   input  logic [NUM_IRQ-1:0] mask_i,
   input  logic               deep_sleep_i,
   input  logic               dbg_conn_i,
   output logic               pd_req_o,
   input  logic               pd_ack_i,
   output logic               pu_req_o,
   input  logic               pu_ack_i,
   output logic               ret_save_o,
   output logic               ret_restore_o,
   input  logic               pmu_hold_i,
   output logic               core_clk_en_o,
   output logic               core_release_o,
   output logic [NUM_IRQ-1:0] wake_reason_o
);
   generate
      if (NUM_IRQ < 1 || NUM_IRQ > 1024) begin : g_bad_width
         $error("wake_ctrl: NUM_IRQ out of range");
      end
   endgenerate

   wake_st_e st;
   logic     hit;
   logic     running;

   assign running = (st == ST_RUN);

   wake_irq_latch #(.NUM_IRQ(NUM_IRQ)) u_latch (
      .clk       (clk_aon),
      .rst_n     (rst_n),
      .irq_i     (irq_i),
      .ld_i      (mask_ld_i),
      .ld_data_i (mask_i),
      .ld_ok_i   (running || (st == ST_MCAP)),
      .collect_i (!running),
      .clear_i   (running && deep_sleep_i),
      .show_i    (running),
      .hit_o     (hit),
      .reason_o  (wake_reason_o)
   );

   wake_seq #(.PWRDN_EN(PWRDN_EN)) u_seq (
      .clk       (clk_aon),
      .rst_n     (rst_n),
      .sleep_i   (deep_sleep_i),
      .dbg_i     (dbg_conn_i),
      .hit_i     (hit),
      .dn_ack_i  (pd_ack_i),
      .up_ack_i  (pu_ack_i),
      .hold_i    (pmu_hold_i),
      .state_o   (st),
      .clk_en_o  (core_clk_en_o),
      .release_o (core_release_o),
      .dn_req_o  (pd_req_o),
      .up_req_o  (pu_req_o),
      .save_o    (ret_save_o),
      .restore_o (ret_restore_o)
   );

   // R9
   abort_path_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
      (st == ST_MCAP && hit) |=> (core_clk_en_o && !core_release_o && !pd_req_o));
endmodule

// File: tb/wake_ctrl_test.sv
module wake_ctrl_test;
   localparam int N = 8;

   typedef struct packed {
      logic [7:0] irq;
      logic       mld;
      logic [7:0] min;
      logic       slp;
      logic       dbg;
      logic       dack;
      logic       uack;
      logic       hold;
      logic [5:0] o;
      logic [7:0] rsn;
      logic [3:0] req;
   } vec_t;

   // o = {release, clk_en, pd_req, pu_req, ret_save, ret_restore}
   localparam vec_t TBL [31] = '{
      '{8'h00,1'b1,8'h05,1'b0,1'b0,1'b0,1'b0,1'b0,6'b110000,8'h00,4'd1}, // R1 load
      '{8'h00,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,6'b010000,8'h00,4'd4}, // R4
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b000000,8'h00,4'd4}, // R4
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b001010,8'h00,4'd5}, // R5
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b001000,8'h00,4'd5}, // R5
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,6'b000000,8'h00,4'd5}, // R5
      '{8'h02,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,6'b000000,8'h00,4'd2}, // R2
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b000000,8'h00,4'd5}, // R5
      '{8'h04,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b000100,8'h00,4'd6}, // R6
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b000100,8'h00,4'd6}, // R6
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,6'b000001,8'h00,4'd6}, // R6
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,6'b000000,8'h00,4'd6}, // R6
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,6'b010000,8'h00,4'd6}, // R6
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,6'b010000,8'h00,4'd7}, // R7
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b110000,8'h04,4'd3}, // R3
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b110000,8'h04,4'd3}, // R3
      '{8'h01,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,6'b010000,8'h00,4'd3}, // R3
      '{8'h01,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b010000,8'h00,4'd9}, // R9
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b110000,8'h01,4'd9}, // R9
      '{8'h00,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,1'b0,6'b010000,8'h00,4'd8}, // R8
      '{8'h00,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,6'b000000,8'h00,4'd8}, // R8
      '{8'h00,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,6'b000000,8'h00,4'd8}, // R8
      '{8'h02,1'b1,8'hFF,1'b0,1'b1,1'b0,1'b0,1'b0,6'b000000,8'h00,4'd1}, // R1 late load
      '{8'h02,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,6'b000000,8'h00,4'd1}, // R1
      '{8'h01,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,6'b010000,8'h00,4'd8}, // R8
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b110000,8'h01,4'd8}, // R8
      '{8'h00,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,6'b010000,8'h00,4'd4}, // R4
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b000000,8'h00,4'd4}, // R4
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b001010,8'h00,4'd5}, // R5
      '{8'h04,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b010000,8'h00,4'd9}, // R9
      '{8'h00,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,6'b110000,8'h04,4'd9}  // R9
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq = '0, min = '0;
   logic         mld = 1'b0, slp = 1'b0, dbg = 1'b0;
   logic         dack = 1'b0, uack = 1'b0, hold = 1'b0;

   logic         pd_req, pu_req, sav, rst_p, cen, rel;
   logic [N-1:0] rsn;
   logic         c_pd_req, c_pu_req, c_sav, c_rst, c_cen, c_rel;
   logic [N-1:0] c_rsn;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   wake_ctrl #(.NUM_IRQ(N), .PWRDN_EN(1'b1)) uut (
      .clk_aon(clk), .rst_n(rst_n), .irq_i(irq), .mask_ld_i(mld), .mask_i(min),
      .deep_sleep_i(slp), .dbg_conn_i(dbg), .pd_req_o(pd_req), .pd_ack_i(dack),
      .pu_req_o(pu_req), .pu_ack_i(uack), .ret_save_o(sav), .ret_restore_o(rst_p),
      .pmu_hold_i(hold), .core_clk_en_o(cen), .core_release_o(rel),
      .wake_reason_o(rsn));

   wake_ctrl #(.NUM_IRQ(N), .PWRDN_EN(1'b0)) uut_cs (
      .clk_aon(clk), .rst_n(rst_n), .irq_i(irq), .mask_ld_i(mld), .mask_i(min),
      .deep_sleep_i(slp), .dbg_conn_i(dbg), .pd_req_o(c_pd_req), .pd_ack_i(dack),
      .pu_req_o(c_pu_req), .pu_ack_i(uack), .ret_save_o(c_sav), .ret_restore_o(c_rst),
      .pmu_hold_i(hold), .core_clk_en_o(c_cen), .core_release_o(c_rel),
      .wake_reason_o(c_rsn));

   task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      irq = '0; mld = 1'b0; min = '0; slp = 1'b0; dbg = 1'b0;
      dack = 1'b0; uack = 1'b0; hold = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R4 reset state
      chk("R4 reset", {rel, cen, pd_req, pu_req, sav, rst_p, rsn},
          {6'b110000, 8'h00});

      for (int i = 0; i < 31; i++) begin
         irq = TBL[i].irq; mld = TBL[i].mld; min = TBL[i].min; slp = TBL[i].slp;
         dbg = TBL[i].dbg; dack = TBL[i].dack; uack = TBL[i].uack; hold = TBL[i].hold;
         @(negedge clk);
         chk($sformatf("R%0d vec%0d", TBL[i].req, i),
             {rel, cen, pd_req, pu_req, sav, rst_p, rsn}, {TBL[i].o, TBL[i].rsn});
      end

      // R1: reset clears the enable copy; no line wakes afterwards
      idle(); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      slp = 1'b1; dbg = 1'b1;
      @(negedge clk);
      slp = 1'b0; irq = 8'hFF;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R1 cleared mask", {rel, cen, pd_req, pu_req, sav, rst_p, rsn},
             {6'b000000, 8'h00});
      end

      // R10: clock-stop-only variant
      idle(); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      mld = 1'b1; min = 8'h80;
      @(negedge clk);
      mld = 1'b0; min = '0; slp = 1'b1;
      @(negedge clk);
      slp = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R10 stays clock-stopped",
             {c_rel, c_cen, c_pd_req, c_pu_req, c_sav, c_rst, c_rsn},
             {6'b000000, 8'h00});
      end
      irq = 8'h80;
      @(negedge clk);
      irq = '0;
      chk("R10 wake to hold", {c_rel, c_cen, c_pd_req, c_pu_req, c_sav, c_rst, c_rsn},
          {6'b010000, 8'h00});
      @(negedge clk);
      chk("R10 released", {c_rel, c_cen, c_pd_req, c_pu_req, c_sav, c_rst, c_rsn},
          {6'b110000, 8'h80});

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule